// File: doc/BRIEF.md
# Integer-Ratio Clock Divider with Aligned Data Crossing

The block takes a fast clock, divides it by an integer parameter and provides a slow clock together with a one-cycle-ahead flag. The flag is high in the fast cycle whose closing edge is also an active edge of the slow clock. Because every slow edge lands on a fast edge, data can pass between the two domains without synchronizer flops. Each transfer only has to be qualified by the ahead flag.

Two small queues carry data across, one in each direction. All flops run on the fast clock. The slow domain's state changes only on fast edges that close a flagged cycle, which are exactly the slow clock's rising edges. The fast-to-slow queue accepts writes on any fast cycle, but the slow reader sees new entries only at slow edges. The slow-to-fast queue accepts at most one entry per slow period, however long the slow writer holds its enable, and the fast reader may drain it on any fast cycle.

Top module: `ratio_xfer`

## Requirements
- R1: While reset is held and at release, `clk_ready` is 0, `slow_clk` is 1, both `*_deq_vld` outputs are 0 and both `*_enq_rdy` outputs are 1.
- R2: Counting fast edges from 0 at the first edge after reset release, `clk_ready` is high in the cycle before edge j exactly when j mod DIV equals DIV-1. It is never high in two consecutive cycles.
- R3: In the cycle before edge j, `slow_clk` is 1 exactly when j mod DIV is below DIV/2. Its rising edges therefore follow fast edges that close a `clk_ready` cycle.
- R4: `fs_enq_rdy` is 1 exactly when the fast-to-slow queue holds fewer than DEPTH entries. A fast write (`fs_enq_en` with `fs_enq_rdy`) is taken on any fast edge.
- R5: `fs_deq_vld` shows the queue's occupancy as it was right after the most recent edge that closed a `clk_ready` cycle. It changes only on such edges.
- R6: A slow-side read removes one entry only on an edge that closes a `clk_ready` cycle with `fs_deq_en` and `fs_deq_vld` high. Holding `fs_deq_en` for a whole slow period removes exactly one entry.
- R7: A slow-side write to the slow-to-fast queue is taken only on an edge that closes a `clk_ready` cycle with `sf_enq_en` and `sf_enq_rdy` high. Holding `sf_enq_en` for a whole slow period adds exactly one entry.
- R8: `sf_enq_rdy` is 1 exactly when free space, as computed right after the most recent slow edge, is nonzero. It changes only on such edges.
- R9: `sf_deq_vld` is 1 exactly when the slow-to-fast queue holds an entry. A fast read (`sf_deq_en` with `sf_deq_vld`) is taken on any fast edge.
- R10: Both queues deliver data in write order, with no loss and no duplication, holding up to DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_ready | output | 1 | High when the next fast edge is a slow edge |
| slow_clk | output | 1 | Divided clock, high for the first DIV/2 fast cycles of each period |
| fs_enq_en | input | 1 | Fast-side write request, fast-to-slow queue |
| fs_enq_data | input | W | Fast-side write data |
| fs_enq_rdy | output | 1 | Fast-to-slow queue has room |
| fs_deq_en | input | 1 | Slow-side read request |
| fs_deq_data | output | W | Oldest entry visible to the slow side |
| fs_deq_vld | output | 1 | Slow side sees at least one entry |
| sf_enq_en | input | 1 | Slow-side write request, slow-to-fast queue |
| sf_enq_data | input | W | Slow-side write data |
| sf_enq_rdy | output | 1 | Slow side sees free space |
| sf_deq_en | input | 1 | Fast-side read request |
| sf_deq_data | output | W | Oldest entry of the slow-to-fast queue |
| sf_deq_vld | output | 1 | Slow-to-fast queue is not empty |

## Verification
`clk_ready` and `slow_clk` are predicted from the number of fast edges since reset release. Ready and valid flags on the fast side reflect a write or read one edge later. Slow-side flags move only after the edge that closes the next `clk_ready` cycle, so an entry written several cycles before a slow edge stays invisible until that edge. The bench samples every output at the falling edge, after the rising edge that produced it and before the next one. It compares each sample with an arithmetic prediction indexed by that edge count. Sequence-numbered data, run at ratios 12 and 48 through fill, mixed and drain phases, checks order and completeness.

// File: rtl/ratio_xfer_pkg.sv
package ratio_xfer_pkg;
    // Which side of a crossing queue lives in the divided domain
    typedef enum logic {
        XFER_F2S = 1'b0,   // writer fast, reader slow
        XFER_S2F = 1'b1    // writer slow, reader fast
    } xfer_dir_e;
endpackage

// File: rtl/ratio_xfer_div.sv
module ratio_xfer_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic slow_clk
);
    localparam int CNTW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [CNTW-1:0] LAST  = CNTW'(DIV - 1);
    localparam logic [CNTW-1:0] HALFV = CNTW'(HALF);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            slow;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
        st_d.slow = (st_d.cnt < HALFV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.slow <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick     = (st_q.cnt == LAST);
    assign slow_clk = st_q.slow;
endmodule

// File: rtl/ratio_xfer_fifo.sv
module ratio_xfer_fifo
    import ratio_xfer_pkg::*;
#(
    parameter xfer_dir_e DIR   = XFER_F2S,
    parameter int        DEPTH = 4,
    parameter int        W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         enq_en,
    input  logic [W-1:0] enq_data,
    output logic         enq_rdy,
    input  logic         deq_en,
    output logic [W-1:0] deq_data,
    output logic         deq_vld
);
    localparam int  PW        = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int  CW        = $clog2(DEPTH + 1);
    localparam bit  READ_SLOW = (DIR == XFER_F2S);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;   // true occupancy
        logic [CW-1:0]           view;  // slow side's snapshot: entries (F2S) or free slots (S2F)
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push, pop;
    logic     rdy_int, vld_int;

    generate
        if (READ_SLOW) begin : g_slow_reader
            assign rdy_int = (st_q.cnt < FULLV);
            assign vld_int = (st_q.view != '0);
            assign push    = enq_en && rdy_int;
            assign pop     = tick && deq_en && vld_int;
        end else begin : g_slow_writer
            assign rdy_int = (st_q.view != '0);
            assign vld_int = (st_q.cnt != '0);
            assign push    = tick && enq_en && rdy_int;
            assign pop     = deq_en && vld_int;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = enq_data;
            st_d.wp = (st_q.wp == LASTP) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == LASTP) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        if (tick) begin
            st_d.view = READ_SLOW ? st_d.cnt : (FULLV - st_d.cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mem  <= '0;
            st_q.wp   <= '0;
            st_q.rp   <= '0;
            st_q.cnt  <= '0;
            st_q.view <= READ_SLOW ? '0 : FULLV;
        end else begin
            st_q <= st_d;
        end
    end

    assign enq_rdy  = rdy_int;
    assign deq_vld  = vld_int;
    assign deq_data = st_q.mem[st_q.rp];
endmodule

// File: rtl/ratio_xfer.sv
module ratio_xfer
    import ratio_xfer_pkg::*;
#(
    parameter int DIV   = 12,
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic         clk_ready,
    output logic         slow_clk,
    input  logic         fs_enq_en,
    input  logic [W-1:0] fs_enq_data,
    output logic         fs_enq_rdy,
    input  logic         fs_deq_en,
    output logic [W-1:0] fs_deq_data,
    output logic         fs_deq_vld,
    input  logic         sf_enq_en,
    input  logic [W-1:0] sf_enq_data,
    output logic         sf_enq_rdy,
    input  logic         sf_deq_en,
    output logic [W-1:0] sf_deq_data,
    output logic         sf_deq_vld
);
    logic tick;

    ratio_xfer_div #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .slow_clk (slow_clk)
    );

    ratio_xfer_fifo #(.DIR(XFER_F2S), .DEPTH(DEPTH), .W(W)) u_f2s (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .enq_en   (fs_enq_en),
        .enq_data (fs_enq_data),
        .enq_rdy  (fs_enq_rdy),
        .deq_en   (fs_deq_en),
        .deq_data (fs_deq_data),
        .deq_vld  (fs_deq_vld)
    );

    ratio_xfer_fifo #(.DIR(XFER_S2F), .DEPTH(DEPTH), .W(W)) u_s2f (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .enq_en   (sf_enq_en),
        .enq_data (sf_enq_data),
        .enq_rdy  (sf_enq_rdy),
        .deq_en   (sf_deq_en),
        .deq_data (sf_deq_data),
        .deq_vld  (sf_deq_vld)
    );

    assign clk_ready = tick;
endmodule

// File: rtl/ratio_xfer_chk.sv
module ratio_xfer_chk #(
    parameter int DEPTH = 4
) (
    input logic clk,
    input logic rst,
    input logic clk_ready,
    input logic slow_clk,
    input logic fs_enq_en,
    input logic fs_enq_rdy,
    input logic fs_deq_en,
    input logic fs_deq_vld,
    input logic sf_enq_en,
    input logic sf_enq_rdy,
    input logic sf_deq_en,
    input logic sf_deq_vld
);
    localparam int CW = $clog2(DEPTH + 1) + 1;

    logic [CW-1:0] occ_fs, occ_sf;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_fs <= '0;
            occ_sf <= '0;
        end else begin
            occ_fs <= occ_fs + CW'(fs_enq_en && fs_enq_rdy)
                             - CW'(clk_ready && fs_deq_en && fs_deq_vld);
            occ_sf <= occ_sf + CW'(clk_ready && sf_enq_en && sf_enq_rdy)
                             - CW'(sf_deq_en && sf_deq_vld);
        end
    end

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        clk_ready |=> !clk_ready);                                  // R2
    AST_SLOW_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_clk) |-> $past(clk_ready));                      // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ_fs <= CW'(DEPTH));                                      // R4
    AST_FS_FULL: assert property (@(posedge clk) disable iff (rst)
        (occ_fs == CW'(DEPTH)) |-> !fs_enq_rdy);                    // R4
    AST_FS_VIEW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(clk_ready) |-> $stable(fs_deq_vld));                 // R5
    AST_SF_RDY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(clk_ready) |-> $stable(sf_enq_rdy));                 // R8
    AST_SF_VLD_OCC: assert property (@(posedge clk) disable iff (rst)
        sf_deq_vld |-> (occ_sf != '0));                             // R9
    AST_SF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ_sf <= CW'(DEPTH));                                      // R10
endmodule

bind ratio_xfer ratio_xfer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_ready  (clk_ready),
    .slow_clk   (slow_clk),
    .fs_enq_en  (fs_enq_en),
    .fs_enq_rdy (fs_enq_rdy),
    .fs_deq_en  (fs_deq_en),
    .fs_deq_vld (fs_deq_vld),
    .sf_enq_en  (sf_enq_en),
    .sf_enq_rdy (sf_enq_rdy),
    .sf_deq_en  (sf_deq_en),
    .sf_deq_vld (sf_deq_vld)
);

// File: tb/ratio_xfer_test.sv
module ratio_xfer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int W     = 8;
    localparam int DIV_A = 12;
    localparam int DIV_B = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;   // 0: uut (DIV_A), 1: uut_b (DIV_B)
    logic fs_enq_en = 0, fs_deq_en = 0, sf_enq_en = 0, sf_deq_en = 0;
    logic [W-1:0] fs_enq_data = '0, sf_enq_data = '0;

    logic a_rdyc, a_slow, a_fs_rdy, a_fs_vld, a_sf_rdy, a_sf_vld;
    logic b_rdyc, b_slow, b_fs_rdy, b_fs_vld, b_sf_rdy, b_sf_vld;
    logic [W-1:0] a_fs_data, a_sf_data, b_fs_data, b_sf_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ratio_xfer #(.DIV(DIV_A), .DEPTH(DEPTH), .W(W)) uut (
        .clk(clk), .rst(rst), .clk_ready(a_rdyc), .slow_clk(a_slow),
        .fs_enq_en(fs_enq_en), .fs_enq_data(fs_enq_data), .fs_enq_rdy(a_fs_rdy),
        .fs_deq_en(fs_deq_en), .fs_deq_data(a_fs_data), .fs_deq_vld(a_fs_vld),
        .sf_enq_en(sf_enq_en), .sf_enq_data(sf_enq_data), .sf_enq_rdy(a_sf_rdy),
        .sf_deq_en(sf_deq_en), .sf_deq_data(a_sf_data), .sf_deq_vld(a_sf_vld));

    ratio_xfer #(.DIV(DIV_B), .DEPTH(DEPTH), .W(W)) uut_b (
        .clk(clk), .rst(rst), .clk_ready(b_rdyc), .slow_clk(b_slow),
        .fs_enq_en(fs_enq_en), .fs_enq_data(fs_enq_data), .fs_enq_rdy(b_fs_rdy),
        .fs_deq_en(fs_deq_en), .fs_deq_data(b_fs_data), .fs_deq_vld(b_fs_vld),
        .sf_enq_en(sf_enq_en), .sf_enq_data(sf_enq_data), .sf_enq_rdy(b_sf_rdy),
        .sf_deq_en(sf_deq_en), .sf_deq_data(b_sf_data), .sf_deq_vld(b_sf_vld));

    wire          m_rdyc   = sel ? b_rdyc   : a_rdyc;
    wire          m_slow   = sel ? b_slow   : a_slow;
    wire          m_fs_rdy = sel ? b_fs_rdy : a_fs_rdy;
    wire          m_fs_vld = sel ? b_fs_vld : a_fs_vld;
    wire [W-1:0]  m_fs_dat = sel ? b_fs_data : a_fs_data;
    wire          m_sf_rdy = sel ? b_sf_rdy : a_sf_rdy;
    wire          m_sf_vld = sel ? b_sf_vld : a_sf_vld;
    wire [W-1:0]  m_sf_dat = sel ? b_sf_data : a_sf_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    // Run one ratio: fill, mixed, drain phases with a sequence-numbered stream.
    task automatic run_ratio(input int div);
        int mc = 0, mv = 0;            // fast-to-slow: occupancy, slow-visible count
        int mc2 = 0, mf = DEPTH;       // slow-to-fast: occupancy, slow-visible free
        int fs_sent = 0, fs_rcv = 0, sf_sent = 0, sf_rcv = 0;
        int seg = 50 * div;
        rst = 1'b1;
        fs_enq_en = 0; fs_deq_en = 0; sf_enq_en = 0; sf_deq_en = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 clk_ready", 32'(m_rdyc), 0);
        chk("R1 slow_clk", 32'(m_slow), 1);
        chk("R1 fs_deq_vld", 32'(m_fs_vld), 0);
        chk("R1 sf_deq_vld", 32'(m_sf_vld), 0);
        chk("R1 fs_enq_rdy", 32'(m_fs_rdy), 1);
        chk("R1 sf_enq_rdy", 32'(m_sf_rdy), 1);
        rst = 1'b0;
        for (int j = 0; j < 3 * seg; j++) begin
            int  ph   = j / seg;
            bit  rc   = ((j % div) == div - 1);
            bit  p1, q1, p2, q2;
            chk("R2 clk_ready", 32'(m_rdyc), 32'(rc));
            chk("R3 slow_clk", 32'(m_slow), 32'((j % div) < div / 2));
            chk("R4 fs_enq_rdy", 32'(m_fs_rdy), 32'(mc < DEPTH));
            chk("R5 fs_deq_vld", 32'(m_fs_vld), 32'(mv != 0));
            if (mv != 0) chk("R10 fs order", 32'(m_fs_dat), 32'(fs_rcv[W-1:0]));
            chk("R8 sf_enq_rdy", 32'(m_sf_rdy), 32'(mf != 0));
            chk("R9 sf_deq_vld", 32'(m_sf_vld), 32'(mc2 != 0));
            if (mc2 != 0) chk("R10 sf order", 32'(m_sf_dat), 32'(sf_rcv[W-1:0]));
            // fast-side stimulus, any cycle
            fs_enq_en = (ph == 2) ? 1'b0 : ($urandom_range(0, 3) != 0);
            sf_deq_en = (ph == 0) ? 1'b0 : (ph == 2) ? 1'b1 : ($urandom_range(0, 1) != 0);
            fs_enq_data = fs_sent[W-1:0];
            // slow-side stimulus, held for a whole slow period (R6, R7)
            if ((j % div) == 0) begin
                fs_deq_en = (ph == 0) ? 1'b0 : (ph == 2) ? 1'b1 : ($urandom_range(0, 1) != 0);
                sf_enq_en = (ph == 2) ? 1'b0 : (ph == 0) ? 1'b1 : ($urandom_range(0, 1) != 0);
            end
            sf_enq_data = sf_sent[W-1:0];
            // expected effect of the coming edge
            p1 = fs_enq_en && (mc < DEPTH);
            q1 = rc && fs_deq_en && (mv != 0);          // R6
            p2 = rc && sf_enq_en && (mf != 0);          // R7
            q2 = sf_deq_en && (mc2 != 0);
            mc = mc + int'(p1) - int'(q1);
            if (rc) mv = mc;
            mc2 = mc2 + int'(p2) - int'(q2);
            if (rc) mf = DEPTH - mc2;
            fs_sent += int'(p1); fs_rcv += int'(q1);
            sf_sent += int'(p2); sf_rcv += int'(q2);
            @(negedge clk);
        end
        // R6/R10: everything written was read exactly once, queues empty
        chk("R6 fs delivered all", 32'(fs_rcv), 32'(fs_sent));
        chk("R10 fs traffic seen", 32'(fs_sent > DEPTH), 1);
        chk("R7 sf delivered all", 32'(sf_rcv), 32'(sf_sent));
        chk("R10 sf traffic seen", 32'(sf_sent > DEPTH), 1);
        chk("R5 fs empty at end", 32'(m_fs_vld), 0);
        chk("R9 sf empty at end", 32'(m_sf_vld), 0);
    endtask

    initial begin
        sel = 1'b0;
        run_ratio(DIV_A);
        sel = 1'b1;
        run_ratio(DIV_B);
        done = 1;
        summary();
    end
endmodule